// File: doc/BRIEF.md
# SPI Port with Multi-Master Fault Detection

This block is an 8-bit serial peripheral port. A control bit makes it either the master or a slave. As master it drives the serial clock and the outgoing data line and samples the returning data line. As slave the three pins change roles: the clock and the incoming data are inputs, and the port drives the returning data line while its select input is low. A programmable divider derives the serial clock from the system clock. A simple register bus gives access to control, status, divider, transmit and receive registers.

On a shared bus a second master may select this port while it is still acting as master. When fault detection is enabled, the port sees its select input go low while it is master. It then leaves master mode at once, aborts any transfer in progress and releases its drivers. It also latches a sticky fault flag, which can raise an interrupt.

Top module: `spiMfPort`

## Requirements
- R1: After reset, reads return CTRL=0x00, STAT=0x00, PRE=0x00, TXD=0x00 and RXD=0xFF. The register addresses are: 0 CTRL (bit0 master, bit1 fault-detect enable, bit2 done-interrupt enable, bit3 fault-interrupt enable), 1 STAT (bit0 ready, bit1 fault, bit2 busy; writing 1 to bit0 or bit1 clears that bit), 2 PRE, 3 TXD, 4 RXD (read-only).
- R2: In master mode sckOe is 1, mosiOe is 1 only during a transfer, and misoOe is 0. In slave mode sckOe and mosiOe are 0, and misoOe is 1 exactly while the synchronized ssN is low.
- R3: In master mode each SCK level lasts PRE+1 clock cycles, so the serial clock period is 2*(PRE+1) cycles.
- R4: In master mode, a TXD write starts a transfer of 8 bits, MSB first, in mode 0. MOSI is valid while SCK is low, and MISO is sampled on each SCK rising edge. The received byte appears in RXD, and STAT ready becomes 1 on the eighth sample. The ready bit clears when a new transfer starts.
- R5: In slave mode, a low ssN loads TXD for sending, with its MSB on MISO. Each rising edge of sckIn samples mosiIn, and the next bit follows each falling edge. After eight samples RXD holds the byte received and STAT ready is set.
- R6: When CTRL bit1 is set, CTRL bit0 is set and ssN is low, CTRL bit0 reads 0 and STAT fault reads 1 within three clock cycles of ssN falling.
- R7: When CTRL bit1 is clear, a low ssN in master mode leaves CTRL bit0 and STAT fault unchanged.
- R8: A fault during a transfer ends it. SCK goes low, mosiOe and sckOe go to 0, busy clears, and ready stays 0.
- R9: The fault flag stays set until 1 is written to STAT bit1. Writing 0 to that bit has no effect.
- R10: irq = (ready AND CTRL bit2) OR (fault AND CTRL bit3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register address |
| busWe | input | 1 | Register write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt request |
| ssN | input | 1 | Active-low select from another master |
| sckIn | input | 1 | Serial clock input (slave) |
| sckOut | output | 1 | Serial clock output (master) |
| sckOe | output | 1 | Serial clock output enable |
| mosiIn | input | 1 | Data input (slave) |
| mosiOut | output | 1 | Data output (master) |
| mosiOe | output | 1 | MOSI output enable |
| misoIn | input | 1 | Data input (master) |
| misoOut | output | 1 | Data output (slave) |
| misoOe | output | 1 | MISO output enable |

## Verification
The hardest case to reach is a collision in the middle of a master transfer, because the abort must land while SCK is partway through its bytes. The bench starts a transfer with a slow divider and counts SCK rising edges at the port. After the third edge it pulls ssN low. It then checks that SCK drops and the drivers release, and that the ready flag never rises even after the transfer would have ended. Random bytes and dividers are run in both modes around this directed case.

// File: rtl/spiMfPkg.sv
package spiMfPkg;
  localparam int DATA_W = 8;
  localparam int PRE_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PRE  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TXD  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RXD  = 3'd4;

  localparam int CB_MASTER = 0;
  localparam int CB_DETEN  = 1;
  localparam int CB_DONEIE = 2;
  localparam int CB_FLTIE  = 3;
  localparam int CTRL_W    = 4;

  typedef struct packed {
    logic load;    // shift register <- transmit byte
    logic sample;  // capture the incoming bit
    logic shift;   // advance the shift register
    logic commit;  // write the full byte to the receive register
  } dpCtlT;
endpackage

// File: rtl/spiMfDatapath.sv
module spiMfDatapath
  import spiMfPkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtlT        ctl,
  input  logic         txWe,
  input  logic [W-1:0] wdata,
  input  logic         inBit,
  output logic [W-1:0] txReg,
  output logic [W-1:0] rxReg,
  output logic         outBit
);
  logic [W-1:0] shiftReg;
  logic         bitLatch;
  logic [W-1:0] loadVal;

  assign loadVal = txWe ? wdata : txReg;
  assign outBit  = shiftReg[W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '0;
      rxReg    <= '1;
      shiftReg <= '0;
      bitLatch <= 1'b0;
    end else begin
      if (txWe)       txReg    <= wdata;
      if (ctl.load)   shiftReg <= loadVal;
      else if (ctl.shift) shiftReg <= {shiftReg[W-2:0], bitLatch};
      if (ctl.sample) bitLatch <= inBit;
      if (ctl.commit) rxReg    <= {shiftReg[W-2:0], inBit};
    end
  end
endmodule

// File: rtl/spiMfControl.sv
module spiMfControl
  import spiMfPkg::*;
#(
  parameter int W  = DATA_W,
  parameter int PW = PRE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [W-1:0]      busWdata,
  input  logic              ssN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output dpCtlT             ctl,
  output logic              txWe,
  output logic              inBit,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [PW-1:0]     preReg,
  output logic              readyFlag,
  output logic              faultFlag,
  output logic              busy,
  output logic              sckReg,
  output logic              slaveSel,
  output logic              irq
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [1:0] ssSy, sckSy, mosiSy;
  logic ssLow, ssLowPrev, sckPrev, sckRise, sckFall;
  logic masterMode, faultHit, masterStart, slaveStart, tick;
  logic ctrlWe, statWe, preWe;
  logic mSample, mShift, sSample, sShift;
  logic [PW-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt, slvCnt;

  // two-flop synchronizers for the asynchronous pin inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssSy <= 2'b11; sckSy <= 2'b00; mosiSy <= 2'b00;
      ssLowPrev <= 1'b0; sckPrev <= 1'b0;
    end else begin
      ssSy <= {ssSy[0], ssN}; sckSy <= {sckSy[0], sckIn}; mosiSy <= {mosiSy[0], mosiIn};
      ssLowPrev <= ssLow; sckPrev <= sckSy[1];
    end
  end

  assign ssLow   = !ssSy[1];
  assign sckRise = sckSy[1] && !sckPrev;
  assign sckFall = !sckSy[1] && sckPrev;

  assign masterMode = ctrlReg[CB_MASTER];
  assign ctrlWe = busWe && (busAddr == ADR_CTRL);
  assign statWe = busWe && (busAddr == ADR_STAT);
  assign preWe  = busWe && (busAddr == ADR_PRE);
  assign txWe   = busWe && (busAddr == ADR_TXD);

  assign faultHit    = masterMode && ctrlReg[CB_DETEN] && ssLow;
  assign masterStart = txWe && masterMode && !busy && !faultHit;
  assign slaveSel    = !masterMode && ssLow;
  assign slaveStart  = slaveSel && !ssLowPrev;
  assign tick        = busy && (divCnt == preReg);

  // master strobes: rising SCK samples, falling SCK shifts
  assign mSample = tick && !sckReg && !faultHit;
  assign mShift  = tick && sckReg && (bitCnt != FULL) && !faultHit;
  // slave strobes follow the synchronized pin clock
  assign sSample = slaveSel && !slaveStart && sckRise && (slvCnt < FULL);
  assign sShift  = slaveSel && !slaveStart && sckFall && (slvCnt != '0) && (slvCnt < FULL);

  assign ctl.load   = masterStart || slaveStart;
  assign ctl.sample = mSample || sSample;
  assign ctl.shift  = mShift || sShift;
  assign ctl.commit = (mSample && bitCnt == LAST) || (sSample && slvCnt == LAST);

  assign inBit = masterMode ? misoIn : mosiSy[1];
  assign irq   = (readyFlag && ctrlReg[CB_DONEIE]) || (faultFlag && ctrlReg[CB_FLTIE]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0; preReg <= '0; readyFlag <= 1'b0; faultFlag <= 1'b0;
    end else begin
      if (ctrlWe) ctrlReg <= busWdata[CTRL_W-1:0];
      if (faultHit) ctrlReg[CB_MASTER] <= 1'b0;
      if (preWe) preReg <= busWdata[PW-1:0];
      if (faultHit) faultFlag <= 1'b1;
      else if (statWe && busWdata[1]) faultFlag <= 1'b0;
      if (ctl.commit) readyFlag <= 1'b1;
      else if (masterStart || (statWe && busWdata[0])) readyFlag <= 1'b0;
    end
  end

  // master clock generator and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; sckReg <= 1'b0; divCnt <= '0; bitCnt <= '0;
    end else if (faultHit) begin
      busy <= 1'b0; sckReg <= 1'b0; divCnt <= '0;
    end else if (masterStart) begin
      busy <= 1'b1; sckReg <= 1'b0; divCnt <= '0; bitCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        sckReg <= !sckReg;
        if (!sckReg) bitCnt <= bitCnt + 1'b1;
        else if (bitCnt == FULL) busy <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slvCnt <= '0;
    else if (slaveStart) slvCnt <= '0;
    else if (sSample) slvCnt <= slvCnt + 1'b1;
  end
endmodule

// File: rtl/spiMfPort.sv
module spiMfPort
  import spiMfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  input  logic              ssN,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe
);
  dpCtlT ctl;
  logic txWe, inBit, outBit, readyFlag, faultFlag, busy, sckReg, slaveSel, masterMode;
  logic [CTRL_W-1:0] ctrlReg;
  logic [PRE_W-1:0]  preReg;
  logic [DATA_W-1:0] txReg, rxReg;

  spiMfControl #(.W(DATA_W), .PW(PRE_W)) u_ctrl (
    .clk, .rstN, .busAddr, .busWe, .busWdata, .ssN, .sckIn, .mosiIn, .misoIn,
    .ctl, .txWe, .inBit, .ctrlReg, .preReg, .readyFlag, .faultFlag, .busy,
    .sckReg, .slaveSel, .irq
  );

  spiMfDatapath #(.W(DATA_W)) u_dp (
    .clk, .rstN, .ctl, .txWe, .wdata(busWdata), .inBit, .txReg, .rxReg, .outBit
  );

  assign masterMode = ctrlReg[CB_MASTER];
  assign sckOut  = sckReg;
  assign sckOe   = masterMode;
  assign mosiOut = outBit;
  assign mosiOe  = masterMode && busy;
  assign misoOut = outBit;
  assign misoOe  = slaveSel;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_CTRL: busRdata = DATA_W'(ctrlReg);
      ADR_STAT: busRdata = DATA_W'({busy, faultFlag, readyFlag});
      ADR_PRE:  busRdata = DATA_W'(preReg);
      ADR_TXD:  busRdata = txReg;
      ADR_RXD:  busRdata = rxReg;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/spiMfChecker.sv
module spiMfChecker
  import spiMfPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              sckOut,
  input logic              sckOe,
  input logic              mosiOe,
  input logic              misoOe,
  input logic              masterMode,
  input logic              faultFlag
);
  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mosiOe, misoOe})); // R2

  AST_SCK_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    sckOut |-> (mosiOe && sckOe)); // R8

  AST_FAULT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> (!masterMode && !mosiOe && !sckOut)); // R6

  AST_MASTER_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(masterMode) && !$past(busWe && busAddr == ADR_CTRL)) |-> faultFlag); // R6

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !(busWe && busAddr == ADR_STAT && busWdata[1])) |=> faultFlag); // R9
endmodule

bind spiMfPort spiMfChecker u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe),
  .masterMode(masterMode), .faultFlag(faultFlag)
);

// File: tb/sim_spiMfPort.sv
module sim_spiMfPort;
  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic irq, ssN = 1'b1, sckIn = 1'b0, sckOut, sckOe, mosiIn = 1'b0, mosiOut, mosiOe;
  logic misoIn = 1'b0, misoOut, misoOe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spiMfPort u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  function automatic int halfCycles(input logic [7:0] pre);
    return int'(pre) + 1;
  endfunction

  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] slv, input logic [7:0] pre,
                            input logic [7:0] ctrlVal);
    logic [7:0] cap = '0, d;
    int rises = 0, cyc = 0, lastRise = 0;
    bit prev = 1'b0, periodOk = 1'b1, oeOk = 1'b1;
    wr(3'd2, pre);
    wr(3'd0, ctrlVal | 8'h01);
    misoIn = slv[7];
    wr(3'd3, tx);
    while (rises < 8 && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (sckOut && !prev) begin
        cap = {cap[6:0], mosiOut};
        if (rises > 0 && (cyc - lastRise) != 2 * halfCycles(pre)) periodOk = 1'b0;
        if (!(sckOe && mosiOe && !misoOe)) oeOk = 1'b0;
        lastRise = cyc; rises++;
        if (rises < 8) misoIn = slv[7 - rises];
      end
      prev = sckOut;
    end
    chk(periodOk, "R3 sck period", lastRise, 2 * halfCycles(pre));
    chk(oeOk, "R2 master pin roles", {sckOe, mosiOe, misoOe}, 3'b110);
    chk(cap == tx, "R4 mosi byte", cap, tx);
    rd(3'd1, d);
    chk(d[0] == 1'b1, "R4 ready after eighth sample", d, 1);
    repeat (2 * halfCycles(pre) + 2) @(negedge clk);
    rd(3'd1, d);
    chk(d[2] == 1'b0 && sckOut == 1'b0, "R4 idle after transfer", d, 1);
    rd(3'd4, d);
    chk(d == slv, "R4 rx byte", d, slv);
  endtask

  task automatic slaveXfer(input logic [7:0] tx, input logic [7:0] mb);
    logic [7:0] cap = '0, d;
    wr(3'd0, 8'h00);
    wr(3'd3, tx);
    ssN = 1'b0;
    repeat (6) @(negedge clk);
    chk(misoOe && !sckOe && !mosiOe, "R2 slave pin roles", {sckOe, mosiOe, misoOe}, 3'b001);
    for (int i = 7; i >= 0; i--) begin
      mosiIn = mb[i];
      repeat (6) @(negedge clk);
      cap = {cap[6:0], misoOut};
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (6) @(negedge clk);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    chk(cap == tx, "R5 miso byte", cap, tx);
    rd(3'd4, d);
    chk(d == mb, "R5 rx byte", d, mb);
    rd(3'd1, d);
    chk(d[0] == 1'b1, "R5 ready", d, 1);
    wr(3'd1, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(3'd0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
    rd(3'd1, d); chk(d == 8'h00, "R1 stat reset", d, 0);
    rd(3'd2, d); chk(d == 8'h00, "R1 pre reset", d, 0);
    rd(3'd3, d); chk(d == 8'h00, "R1 txd reset", d, 0);
    rd(3'd4, d); chk(d == 8'hFF, "R1 rxd reset", d, 8'hFF);
    chk(irq == 1'b0, "R10 irq reset", irq, 0);

    // directed: fastest divider, then done interrupt
    masterXfer(8'h81, 8'h7E, 8'd0, 8'h04);
    chk(irq == 1'b1, "R10 done irq", irq, 1);
    wr(3'd1, 8'h01);
    chk(irq == 1'b0, "R10 irq clears with ready", irq, 0);

    // random master and slave transfers
    for (int k = 0; k < 6; k++)
      masterXfer(8'($urandom), 8'($urandom), 8'($urandom_range(5, 0)), 8'($urandom) & 8'h02);
    masterXfer(8'hC3, 8'h3C, 8'd7, 8'h00);
    for (int k = 0; k < 3; k++) slaveXfer(8'($urandom), 8'($urandom));

    // R7 detection disabled
    wr(3'd0, 8'h01);
    ssN = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd0, d); chk(d[0] == 1'b1, "R7 master kept", d, 1);
    rd(3'd1, d); chk(d[1] == 1'b0, "R7 no fault", d, 0);
    ssN = 1'b1;
    repeat (4) @(negedge clk);

    // R6 detection in idle master
    wr(3'd0, 8'h0B);
    ssN = 1'b0;
    repeat (3) @(posedge clk);
    rd(3'd0, d); chk(d[0] == 1'b0, "R6 master cleared", d, 0);
    rd(3'd1, d); chk(d[1] == 1'b1, "R6 fault set", d, 1);
    chk(irq == 1'b1, "R10 fault irq", irq, 1);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk(d[1] == 1'b1, "R9 fault sticky", d, 1);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd1, 8'h02);
    rd(3'd1, d); chk(d[1] == 1'b0, "R9 fault cleared", d, 0);
    chk(irq == 1'b0, "R10 irq after clear", irq, 0);

    // R8 fault in mid transfer
    begin
      int rises = 0;
      bit prev = 1'b0;
      wr(3'd2, 8'd3);
      wr(3'd0, 8'h03);
      wr(3'd3, 8'hA5);
      while (rises < 3) begin
        @(negedge clk);
        if (sckOut && !prev) rises++;
        prev = sckOut;
      end
      ssN = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!sckOut && !sckOe && !mosiOe, "R8 pins released", {sckOut, sckOe, mosiOe}, 0);
      repeat (80) @(negedge clk);
      rd(3'd1, d);
      chk(d == 8'h02, "R8 aborted no ready", d, 8'h02);
      ssN = 1'b1;
      repeat (4) @(negedge clk);
      wr(3'd1, 8'h03);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule